// File: doc/BRIEF.md
# Display Identification Block Fetch Sequencer

This block reads the identification record of an attached display through a byte-read engine on the display data channel. The base block of 128 bytes is fetched first. Its extension byte says how many further 128-byte blocks follow, and the sequencer then reads that many, up to a fixed cap. Each block is read in short bursts. For each burst the sequencer clears the engine's receive queue, issues a command that carries a segment, an in-segment offset and a byte count, waits for the engine's busy flag to drop, and then pops the bytes into a local buffer.

A block is accepted only when its bytes sum to zero modulo 256. A block that fails its sum check, or whose burst never completes within the time limit, is read again. When the retries are used up, a failed base block ends the fetch with an error code. A failed extension block ends the fetch quietly, and only the extension blocks read before it are counted. The host pulses `start` and waits for `done`. It then reads the result code, the number of extension blocks and, through a read port, the buffered bytes.

Top module: `edid_fetch_seq`

## Requirements
- R1: After `start` the base block is fetched first, and block k occupies bytes k*128 to k*128+127. An accepted block's bytes can be read back on `buf_addr`/`buf_data` at those same byte indices.
- R2: A block is read in bursts of min(BURST_MAX, remaining) bytes, 16 by default. The bursts are issued in ascending, contiguous offset order.
- R3: Each burst command carries the byte address split into `eng_segment` = address >> 8 and `eng_offset` = address[7:0].
- R4: Before every burst, `eng_fifo_clr` pulses in the cycle right before `eng_go`. The engine raises `eng_busy` from the cycle after `eng_go`. `eng_rd` pops one byte per cycle, and only while `eng_busy` is low.
- R5: If `eng_busy` stays high for TIMEOUT_US microseconds (CLK_PER_US clocks each) after a burst command, that attempt fails with timeout. If it was the base block's last attempt, `status` becomes 1.
- R6: A block passes its check when its 128 bytes sum to 0 modulo 256. A base block that fails this check on its last attempt gives `status` 2.
- R7: A failed attempt, whether from timeout or checksum, is followed by up to MAX_RETRY (2) full re-reads of the same block.
- R8: The number of extension blocks fetched is min(base byte 126, MAX_EXT), with MAX_EXT = 4.
- R9: When extension block j runs out of retries, the fetch stops with `status` 0 and `ext_count` = j-1.
- R10: A base-block failure reports `ext_count` 0.
- R11: `done` is a one-cycle pulse and `busy` is high from the cycle after an accepted `start` through `done`. A `start` while busy is ignored. `status` and `ext_count` change only at `done` and hold until the next `done`.
- R12: After reset `busy`, `done`, `status`, `ext_count` and all engine strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle end-of-fetch pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 checksum error |
| ext_count | output | EXT_W (3) | Extension blocks fetched |
| eng_fifo_clr | output | 1 | Clear the engine receive queue |
| eng_go | output | 1 | Issue burst command |
| eng_segment | output | 8 | Segment field of the command |
| eng_offset | output | 8 | Offset field of the command |
| eng_count | output | CNT_W (5) | Byte count of the command |
| eng_busy | input | 1 | Engine start/busy flag |
| eng_rd | output | 1 | Pop one byte from the queue |
| eng_rdata | input | 8 | Byte at the head of the queue |
| buf_addr | input | OFF_W (10) | Buffer read address |
| buf_data | output | 8 | Buffer byte at `buf_addr` |

## Verification
Clean images with extension bytes of 0, 2 and 7 exercise the fetch path. They separate correct block counting and capping from an off-by-one, and the offset-512 blocks expose a wrong segment split through the buffer contents. Corrupting the first one or three attempts of a block shows the difference between a retry that recovers and one that runs out. Applied to the base block and to a middle extension block, it separates a fatal error from truncation. A hung busy flag does the same for the timeout path and bounds the time limit from below. Seeded random mixes of extension counts and per-block fault counts are compared against a bench predictor.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

   typedef enum logic [1:0] {
      FETCH_OK      = 2'd0,
      FETCH_TIMEOUT = 2'd1,
      FETCH_BADSUM  = 2'd2
   } fetch_status_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_BLK,
      S_CLR,
      S_ISSUE,
      S_WAIT,
      S_DRAIN,
      S_CHECK,
      S_RETRY,
      S_FIN
   } seq_state_e;

endpackage

// File: rtl/edid_us_timer.sv
module edid_us_timer #(
   parameter int CLK_PER_US = 100,
   parameter int TIMEOUT_US = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   localparam int PS_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam int T_W  = $clog2(TIMEOUT_US + 1);

   logic          us_tick;
   logic [T_W-1:0] us_cnt;

   initial begin
      if (CLK_PER_US < 1) $fatal(1, "CLK_PER_US must be at least 1");
      if (TIMEOUT_US < 1) $fatal(1, "TIMEOUT_US must be at least 1");
   end

   generate
      if (CLK_PER_US == 1) begin : g_direct
         assign us_tick = 1'b1;
      end else begin : g_prescale
         logic [PS_W-1:0] ps;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              ps <= '0;
            else if (ps == PS_W'(CLK_PER_US - 1))    ps <= '0;
            else                                     ps <= ps + 1'b1;
         end
         assign us_tick = (ps == PS_W'(CLK_PER_US - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    us_cnt <= '0;
      else if (restart)              us_cnt <= '0;
      else if (us_tick && !expired)  us_cnt <= us_cnt + 1'b1;
   end

   assign expired = (us_cnt == T_W'(TIMEOUT_US));
endmodule

// File: rtl/edid_byte_store.sv
module edid_byte_store #(
   parameter int DEPTH = 640,
   parameter int OFF_W = 10
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [OFF_W-1:0] rd_addr,
   output logic [7:0]       rd_data,
   input  logic [OFF_W-1:0] pk_addr,
   output logic [7:0]       pk_data
);
   logic [7:0] mem [DEPTH];

   initial begin
      if ((1 << OFF_W) < DEPTH) $fatal(1, "OFF_W too narrow for DEPTH");
   end

   always_ff @(posedge clk) begin
      if (wr_en && (wr_addr < OFF_W'(DEPTH))) mem[wr_addr] <= wr_data;
   end

   assign rd_data = (rd_addr < OFF_W'(DEPTH)) ? mem[rd_addr] : 8'h00;
   assign pk_data = (pk_addr < OFF_W'(DEPTH)) ? mem[pk_addr] : 8'h00;
endmodule

// File: rtl/edid_fetch_fsm.sv
module edid_fetch_fsm
   import edid_fetch_pkg::*;
#(
   parameter int BLOCK_BYTES = 128,
   parameter int BURST_MAX   = 16,
   parameter int MAX_EXT     = 4,
   parameter int MAX_RETRY   = 2,
   parameter int OFF_W       = 10,
   parameter int CNT_W       = 5,
   parameter int EXT_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             eng_busy,
   input  logic [7:0]       eng_rdata,
   input  logic             tmo_expired,
   input  logic [7:0]       pk_data,
   output logic             eng_fifo_clr,
   output logic             eng_go,
   output logic [OFF_W-1:0] eng_addr,
   output logic [CNT_W-1:0] eng_count,
   output logic             eng_rd,
   output logic             tmr_restart,
   output logic             wr_en,
   output logic [OFF_W-1:0] wr_addr,
   output logic [7:0]       wr_data,
   output logic             busy,
   output logic             done,
   output logic [1:0]       status,
   output logic [EXT_W-1:0] ext_count
);
   localparam int REM_W = $clog2(BLOCK_BYTES + 1);
   localparam int TRY_W = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

   seq_state_e    state;
   logic [EXT_W-1:0] blk;
   logic [EXT_W-1:0] ext_tgt;
   logic [TRY_W-1:0] tries;
   logic [OFF_W-1:0] addr;
   logic [REM_W-1:0] remain;
   logic [CNT_W-1:0] burst_n;
   logic [CNT_W-1:0] idx;
   logic [7:0]       sum;
   fetch_status_e    fail_kind;
   fetch_status_e    status_q;
   logic [EXT_W-1:0] extcnt_q;

   logic [OFF_W-1:0] blk_base;
   logic [CNT_W-1:0] burst_len;
   logic [EXT_W-1:0] tgt_now;
   logic             last_try;

   assign blk_base  = OFF_W'(int'(blk) * BLOCK_BYTES);
   assign burst_len = (remain > REM_W'(BURST_MAX)) ? CNT_W'(BURST_MAX) : CNT_W'(remain);
   assign tgt_now   = (pk_data > 8'(MAX_EXT)) ? EXT_W'(MAX_EXT) : EXT_W'(pk_data);
   assign last_try  = (tries == TRY_W'(MAX_RETRY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         blk       <= '0;
         ext_tgt   <= '0;
         tries     <= '0;
         addr      <= '0;
         remain    <= '0;
         burst_n   <= '0;
         idx       <= '0;
         sum       <= '0;
         fail_kind <= FETCH_OK;
         status_q  <= FETCH_OK;
         extcnt_q  <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start) begin
                  blk   <= '0;
                  tries <= '0;
                  state <= S_BLK;
               end
            end
            S_BLK: begin
               addr   <= blk_base;
               remain <= REM_W'(BLOCK_BYTES);
               sum    <= '0;
               state  <= S_CLR;
            end
            S_CLR: begin
               burst_n <= burst_len;
               state   <= S_ISSUE;
            end
            S_ISSUE: begin
               idx   <= '0;
               state <= S_WAIT;
            end
            S_WAIT: begin
               if (!eng_busy) begin
                  state <= S_DRAIN;
               end else if (tmo_expired) begin
                  fail_kind <= FETCH_TIMEOUT;
                  state     <= S_RETRY;
               end
            end
            S_DRAIN: begin
               addr   <= addr + 1'b1;
               sum    <= sum + eng_rdata;
               idx    <= idx + 1'b1;
               remain <= remain - 1'b1;
               if (idx == burst_n - 1'b1)
                  state <= (remain == REM_W'(1)) ? S_CHECK : S_CLR;
            end
            S_CHECK: begin
               if (sum == 8'h00) begin
                  tries <= '0;
                  if (blk == '0) begin
                     ext_tgt <= tgt_now;
                     if (tgt_now == '0) begin
                        status_q <= FETCH_OK;
                        extcnt_q <= '0;
                        state    <= S_FIN;
                     end else begin
                        blk   <= EXT_W'(1);
                        state <= S_BLK;
                     end
                  end else if (blk == ext_tgt) begin
                     status_q <= FETCH_OK;
                     extcnt_q <= blk;
                     state    <= S_FIN;
                  end else begin
                     blk   <= blk + 1'b1;
                     state <= S_BLK;
                  end
               end else begin
                  fail_kind <= FETCH_BADSUM;
                  state     <= S_RETRY;
               end
            end
            S_RETRY: begin
               if (!last_try) begin
                  tries <= tries + 1'b1;
                  state <= S_BLK;
               end else begin
                  if (blk == '0) begin
                     status_q <= fail_kind;
                     extcnt_q <= '0;
                  end else begin
                     status_q <= FETCH_OK;
                     extcnt_q <= blk - 1'b1;
                  end
                  state <= S_FIN;
               end
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign eng_fifo_clr = (state == S_CLR);
   assign eng_go       = (state == S_ISSUE);
   assign tmr_restart  = (state == S_ISSUE);
   assign eng_rd       = (state == S_DRAIN);
   assign eng_addr     = addr;
   assign eng_count    = burst_n;
   assign wr_en        = (state == S_DRAIN);
   assign wr_addr      = addr;
   assign wr_data      = eng_rdata;
   assign busy         = (state != S_IDLE);
   assign done         = (state == S_FIN);
   assign status       = status_q;
   assign ext_count    = extcnt_q;
endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq #(
   parameter int BLOCK_BYTES = 128,
   parameter int BURST_MAX   = 16,
   parameter int MAX_EXT     = 4,
   parameter int MAX_RETRY   = 2,
   parameter int EXT_FIELD   = 126,
   parameter int CLK_PER_US  = 100,
   parameter int TIMEOUT_US  = 200000,
   localparam int TOTAL      = (MAX_EXT + 1) * BLOCK_BYTES,
   localparam int OFF_W      = ($clog2(TOTAL) < 9) ? 9 : $clog2(TOTAL),
   localparam int CNT_W      = $clog2(BURST_MAX + 1),
   localparam int EXT_W      = (MAX_EXT > 0) ? $clog2(MAX_EXT + 1) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic [1:0]       status,
   output logic [EXT_W-1:0] ext_count,
   output logic             eng_fifo_clr,
   output logic             eng_go,
   output logic [7:0]       eng_segment,
   output logic [7:0]       eng_offset,
   output logic [CNT_W-1:0] eng_count,
   input  logic             eng_busy,
   output logic             eng_rd,
   input  logic [7:0]       eng_rdata,
   input  logic [OFF_W-1:0] buf_addr,
   output logic [7:0]       buf_data
);
   initial begin
      if (BURST_MAX < 1 || BURST_MAX > 255) $fatal(1, "BURST_MAX out of range");
      if (EXT_FIELD >= BLOCK_BYTES)         $fatal(1, "EXT_FIELD outside block");
      if (MAX_RETRY < 0)                    $fatal(1, "MAX_RETRY negative");
   end

   logic             tmo_expired;
   logic             tmr_restart;
   logic             wr_en;
   logic [OFF_W-1:0] wr_addr;
   logic [7:0]       wr_data;
   logic [OFF_W-1:0] eng_addr;
   logic [7:0]       pk_data;

   edid_us_timer #(
      .CLK_PER_US(CLK_PER_US),
      .TIMEOUT_US(TIMEOUT_US)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(tmr_restart),
      .expired(tmo_expired)
   );

   edid_byte_store #(
      .DEPTH(TOTAL),
      .OFF_W(OFF_W)
   ) i_store (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(buf_addr),
      .rd_data(buf_data),
      .pk_addr(OFF_W'(EXT_FIELD)),
      .pk_data(pk_data)
   );

   edid_fetch_fsm #(
      .BLOCK_BYTES(BLOCK_BYTES),
      .BURST_MAX  (BURST_MAX),
      .MAX_EXT    (MAX_EXT),
      .MAX_RETRY  (MAX_RETRY),
      .OFF_W      (OFF_W),
      .CNT_W      (CNT_W),
      .EXT_W      (EXT_W)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .eng_busy    (eng_busy),
      .eng_rdata   (eng_rdata),
      .tmo_expired (tmo_expired),
      .pk_data     (pk_data),
      .eng_fifo_clr(eng_fifo_clr),
      .eng_go      (eng_go),
      .eng_addr    (eng_addr),
      .eng_count   (eng_count),
      .eng_rd      (eng_rd),
      .tmr_restart (tmr_restart),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .busy        (busy),
      .done        (done),
      .status      (status),
      .ext_count   (ext_count)
   );

   assign eng_segment = 8'(eng_addr >> 8);
   assign eng_offset  = eng_addr[7:0];
endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk #(
   parameter int BURST_MAX = 16,
   parameter int MAX_EXT   = 4,
   parameter int CNT_W     = 5,
   parameter int EXT_W     = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [1:0]       status,
   input logic [EXT_W-1:0] ext_count,
   input logic             eng_fifo_clr,
   input logic             eng_go,
   input logic [CNT_W-1:0] eng_count,
   input logic             eng_busy,
   input logic             eng_rd
);
   // R4: queue clear in the cycle before every command
   a_r4_clr_before_go: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> $past(eng_fifo_clr));

   // R4: bytes are popped only after the engine went idle
   a_r4_rd_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rd |-> !eng_busy);

   // R4: at most one engine strobe per cycle
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({eng_fifo_clr, eng_go, eng_rd}));

   // R2: burst size within limits
   a_r2_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> (eng_count != '0 && eng_count <= CNT_W'(BURST_MAX)));

   // R8: extension count never exceeds the cap
   a_r8_ext_cap: assert property (@(posedge clk) disable iff (!rst_n)
      ext_count <= EXT_W'(MAX_EXT));

   // R10: a failure code comes with no extension blocks
   a_r10_fail_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 2'd0) |-> ext_count == '0);

   // R11: done lasts one cycle
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: accepted start raises busy
   a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R11: results only move at done
   a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(status) && $stable(ext_count)));

   // R11: no engine activity while idle
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(eng_fifo_clr || eng_go || eng_rd));
endmodule

bind edid_fetch_seq edid_fetch_chk #(
   .BURST_MAX(BURST_MAX),
   .MAX_EXT  (MAX_EXT),
   .CNT_W    (CNT_W),
   .EXT_W    (EXT_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .status      (status),
   .ext_count   (ext_count),
   .eng_fifo_clr(eng_fifo_clr),
   .eng_go      (eng_go),
   .eng_count   (eng_count),
   .eng_busy    (eng_busy),
   .eng_rd      (eng_rd)
);

// File: tb/test_edid_fetch_seq.sv
`timescale 1ns/1ps
module test_edid_fetch_seq;
   localparam int NBLK = 5;
   localparam int NBYTE = NBLK * 128;
   localparam int CPU = 2;
   localparam int TMO = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       busy, done;
   logic [1:0] status;
   logic [2:0] ext_count;
   logic       eng_fifo_clr, eng_go, eng_rd;
   logic [7:0] eng_segment, eng_offset;
   logic [4:0] eng_count;
   logic       eng_busy;
   logic [7:0] eng_rdata;
   logic [9:0] buf_addr = '0;
   logic [7:0] buf_data;

   logic [7:0] img [0:NBYTE-1];
   int bad_n  [0:NBLK-1];
   int hang_n [0:NBLK-1];
   int att    [0:NBLK-1];
   int cur_addr, rd_ptr, lat, prev_addr, layout_err;
   logic corrupt, hanging;
   int total = 0;
   int nbad  = 0;

   always #10 clk = ~clk;

   edid_fetch_seq #(.CLK_PER_US(CPU), .TIMEOUT_US(TMO)) i_edid_fetch_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .status(status), .ext_count(ext_count), .eng_fifo_clr(eng_fifo_clr),
      .eng_go(eng_go), .eng_segment(eng_segment), .eng_offset(eng_offset),
      .eng_count(eng_count), .eng_busy(eng_busy), .eng_rd(eng_rd),
      .eng_rdata(eng_rdata), .buf_addr(buf_addr), .buf_data(buf_data));

   // byte-read engine model
   assign eng_rdata = img[(cur_addr + rd_ptr) % NBYTE] ^
                      ((corrupt && (cur_addr % 128) == 0 && rd_ptr == 5) ? 8'h01 : 8'h00);

   always @(posedge clk) begin : eng_model
      int a, b;
      if (!rst_n) begin
         eng_busy <= 1'b0; cur_addr <= 0; rd_ptr <= 0; lat <= 0;
         corrupt <= 1'b0; hanging <= 1'b0; prev_addr = 0; layout_err = 0;
         for (int i = 0; i < NBLK; i++) att[i] = 0;
      end else begin
         if (start && !busy) for (int i = 0; i < NBLK; i++) att[i] = 0;
         if (eng_fifo_clr) begin
            rd_ptr <= 0; hanging <= 1'b0; eng_busy <= 1'b0;
         end
         if (eng_go) begin
            a = int'(eng_segment) * 256 + int'(eng_offset);
            b = (a / 128) % NBLK;
            if (a % 128 == 0) att[b] = att[b] + 1;
            else if (a != prev_addr + 16) layout_err = layout_err + 1;
            if (eng_count != 5'd16) layout_err = layout_err + 1;
            prev_addr = a;
            cur_addr <= a; rd_ptr <= 0; eng_busy <= 1'b1;
            lat <= 1 + int'($urandom % 6);
            corrupt <= (att[b] <= bad_n[b]);
            hanging <= (att[b] <= hang_n[b]);
         end else if (eng_busy && !hanging && !eng_fifo_clr) begin
            if (lat <= 1) eng_busy <= 1'b0;
            else lat <= lat - 1;
         end
         if (eng_rd) rd_ptr <= rd_ptr + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic build_image(input int ext);
      for (int b = 0; b < NBLK; b++) begin
         int s;
         s = 0;
         for (int i = 0; i < 127; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            if (b == 0 && i == 126) v = 8'(ext);
            img[b*128+i] = v;
            s += int'(v);
         end
         img[b*128+127] = 8'(256 - (s % 256));
      end
   endtask

   function automatic void predict(input int ext, output int st, output int ec);
      int tgt;
      tgt = (ext > 4) ? 4 : ext;
      st = 0; ec = tgt;
      if (bad_n[0] + hang_n[0] >= 3) begin
         st = (hang_n[0] > 0) ? 1 : 2; ec = 0; return;
      end
      for (int b = 1; b <= tgt; b++)
         if (bad_n[b] + hang_n[b] >= 3) begin ec = b - 1; return; end
   endfunction

   task automatic clear_faults();
      for (int b = 0; b < NBLK; b++) begin bad_n[b] = 0; hang_n[b] = 0; end
   endtask

   task automatic run_scn(input string req, input int ext, input int min_cyc,
                          input bit restart_mid);
      int st, ec, cyc, lerr0, mism;
      build_image(ext);
      predict(ext, st, ec);
      lerr0 = layout_err;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 1;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (restart_mid && cyc == 40) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      check(done == 1'b1, "R11", "done seen", int'(done), 1);
      check(status == 2'(st), req, "status", int'(status), st);
      check(ext_count == 3'(ec), req, "ext_count", int'(ext_count), ec);
      if (min_cyc > 0) check(cyc >= min_cyc, "R5", "cycles before timeout", cyc, min_cyc);
      @(negedge clk);
      check(!done && !busy, "R11", "done one cycle then idle", int'({done, busy}), 0);
      check(layout_err == lerr0, "R2 R3", "burst layout errors", layout_err - lerr0, 0);
      if (st == 0) begin
         mism = 0;
         for (int a = 0; a < (ec + 1) * 128; a++) begin
            buf_addr = 10'(a);
            #1;
            if (buf_data !== img[a]) mism++;
         end
         check(mism == 0, "R1", "buffer byte mismatches", mism, 0);
      end
      if (restart_mid) begin
         int up;
         up = 0;
         repeat (30) begin @(negedge clk); if (busy) up++; end
         check(up == 0, "R11", "start while busy ignored", up, 0);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      total++; nbad++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, nbad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      clear_faults();
      for (int i = 0; i < NBYTE; i++) img[i] = 8'h00;
      repeat (4) @(negedge clk);
      // R12 reset state
      check(busy == 1'b0, "R12", "busy in reset", int'(busy), 0);
      check(done == 1'b0, "R12", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(status == 2'd0, "R12", "status after reset", int'(status), 0);
      check(ext_count == 3'd0, "R12", "ext_count after reset", int'(ext_count), 0);
      check({eng_fifo_clr, eng_go, eng_rd} == 3'b000, "R12", "strobes after reset",
            int'({eng_fifo_clr, eng_go, eng_rd}), 0);

      // R1 R6 R8: clean base only
      run_scn("R8", 0, 0, 1'b0);
      // R3 R8: two extension blocks (offset 256 uses segment 1)
      run_scn("R8", 2, 0, 1'b0);
      // R8 R3: extension byte 7 capped at 4, offsets up to 512+
      run_scn("R8", 7, 0, 1'b0);
      // R7: one corrupted base attempt recovers
      clear_faults(); bad_n[0] = 1;
      run_scn("R7", 3, 0, 1'b0);
      // R7: two corrupted attempts still recover
      clear_faults(); bad_n[2] = 2;
      run_scn("R7", 4, 0, 1'b0);
      // R6 R10: base checksum fails on all attempts
      clear_faults(); bad_n[0] = 3;
      run_scn("R6", 4, 0, 1'b0);
      // R9: extension block 2 exhausts retries
      clear_faults(); bad_n[2] = 3;
      run_scn("R9", 4, 0, 1'b0);
      // R5 R7: one hung base attempt then success
      clear_faults(); hang_n[0] = 1;
      run_scn("R5", 1, 38, 1'b0);
      // R5 R10: base hangs on every attempt
      clear_faults(); hang_n[0] = 3;
      run_scn("R5", 2, 3 * 38, 1'b0);
      // R9: first extension hangs on every attempt
      clear_faults(); hang_n[1] = 3;
      run_scn("R9", 3, 0, 1'b0);
      // R11: start during a fetch is ignored
      clear_faults();
      run_scn("R11", 1, 0, 1'b1);
      // random mixes
      for (int n = 0; n < 10; n++) begin
         int e;
         clear_faults();
         e = int'($urandom % 8);
         for (int b = 0; b < NBLK; b++)
            if ($urandom % 3 == 0) bad_n[b] = int'($urandom % 4);
         if ($urandom % 4 == 0) begin
            int hb;
            hb = int'($urandom % NBLK);
            bad_n[hb] = 0;
            hang_n[hb] = 1 + int'($urandom % 3);
         end
         run_scn("R7 R9", e, 0, 1'b0);
      end

      $display("  test done: total=%0d bad=%0d", total, nbad);
      $finish;
   end
endmodule